// File: doc/BRIEF.md
# Bit-Serial Adder with Set/Reset Carry

This block adds two binary words that arrive one bit per clock cycle, least significant bit first, and returns one sum bit per cycle. The only state carried from one bit position to the next is a single carry bit. That bit is not reloaded every cycle. It is set when both operand bits are one (generate), cleared when both are zero (kill), and left unchanged when exactly one of them is one (propagate).

A word begins with a start pulse, which clears the carry. The operand bits then follow on cycles where the valid strobe is high. Idle cycles may fall between bits. Each accepted bit pair produces a registered sum bit and a sum-valid flag one cycle later. Once the last sum bit has been presented, the carry output holds the overflow of the whole word.

Top module: `serial_rs_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `carry_out` = 0, `sum_valid` = 0 and `sum_bit` = 0.
- R2: A bit pair is accepted on an edge where `in_valid` = 1 and `start` = 0. One cycle later `sum_valid` = 1 and `sum_bit` = `bit_a` XOR `bit_b` XOR the carry held before that edge.
- R3: An accepted pair with `bit_a` = 1 and `bit_b` = 1 sets `carry_out` to 1 in the next cycle.
- R4: An accepted pair with `bit_a` = 0 and `bit_b` = 0 clears `carry_out` to 0 in the next cycle.
- R5: An accepted pair with exactly one bit equal to 1 leaves `carry_out` unchanged.
- R6: When `in_valid` = 0 and `start` = 0, `carry_out` and `sum_bit` hold their values and `sum_valid` is 0 in the next cycle.
- R7: `start` = 1 clears `carry_out` in the next cycle, even when `in_valid`, `bit_a` and `bit_b` are all 1. No bit is accepted in that cycle, so `sum_valid` is 0 in the next cycle.
- R8: After a start pulse and N accepted pairs, the N sum bits taken in arrival order (the first one is the least significant) and the following `carry_out` equal the (N+1)-bit parallel sum of the two operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clears the carry for a new word |
| in_valid | input | 1 | The operand bits are valid this cycle |
| bit_a | input | 1 | Operand A bit |
| bit_b | input | 1 | Operand B bit |
| sum_bit | output | 1 | Registered sum bit |
| sum_valid | output | 1 | `sum_bit` holds a new result |
| carry_out | output | 1 | Stored carry; the final overflow after the last bit |

## Verification
Zero plus zero keeps the carry in the kill state for the whole word. All ones plus all ones generates at every position and ends with an overflow. All ones plus one makes a single generate ride through a long chain of propagates, which separates a carry that truly holds from one that is rebuilt each cycle. Random operands with random idle gaps check that the carry and the sum hold while no bit is valid, and a start cycle carrying a one-one bit pair checks that clearing wins over setting.

// File: rtl/serial_rs_adder.sv
module serial_rs_adder (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic in_valid,
  input  logic bit_a,
  input  logic bit_b,
  output logic sum_bit,
  output logic sum_valid,
  output logic carry_out
);

  logic cy;
  logic take;
  logic gen;
  logic kil;

  assign take = in_valid & ~start;
  assign gen  = take & bit_a & bit_b;
  assign kil  = start | (take & ~bit_a & ~bit_b);

  always_ff @(posedge clk) begin
    if (rst)      cy <= 1'b0;
    else if (kil) cy <= 1'b0;
    else if (gen) cy <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_bit   <= 1'b0;
      sum_valid <= 1'b0;
    end else begin
      sum_valid <= take;
      if (take) sum_bit <= bit_a ^ bit_b ^ cy;
    end
  end

  assign carry_out = cy;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!carry_out && !sum_valid && !sum_bit));

  // R2
  sum_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !start) |=> (sum_valid && sum_bit == ($past(bit_a) ^ $past(bit_b) ^ $past(carry_out))));

  // R3
  carry_set_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !start && bit_a && bit_b) |=> carry_out);

  // R4
  carry_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !start && !bit_a && !bit_b) |=> !carry_out);

  // R5
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !start && (bit_a != bit_b)) |=> $stable(carry_out));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !start) |=> ($stable(carry_out) && $stable(sum_bit) && !sum_valid));

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (!carry_out && !sum_valid));

endmodule

// File: tb/serial_rs_adder_tb_top.sv
module serial_rs_adder_tb_top;

  localparam int W = 8;
  localparam int MAX_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic bit_a = 1'b0;
  logic bit_b = 1'b0;
  logic sum_bit, sum_valid, carry_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit primed = 1'b0;
  bit finished = 1'b0;

  int exp_cy = 0;
  int exp_sv = 0;
  int exp_sb = 0;
  logic [W-1:0] got_word;

  always #2 clk = ~clk;

  serial_rs_adder dut_i (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .bit_a(bit_a), .bit_b(bit_b),
    .sum_bit(sum_bit), .sum_valid(sum_valid), .carry_out(carry_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  task automatic step(input logic r, input logic st, input logic v, input logic a, input logic b);
    int total;
    @(negedge clk);
    if (primed) begin
      // R1 R2 R6 R7: outputs against the cycle model
      check("R2 R6 R7 sum_valid", int'(sum_valid), exp_sv);
      check("R2 R6 sum_bit", int'(sum_bit), exp_sb);
      // R3 R4 R5 R7: stored carry
      check("R3 R4 R5 R7 carry_out", int'(carry_out), exp_cy);
      if (sum_valid) got_word = {sum_bit, got_word[W-1:1]};
    end
    rst = r; start = st; in_valid = v; bit_a = a; bit_b = b;
    @(posedge clk);
    if (r) begin
      exp_cy = 0; exp_sv = 0; exp_sb = 0;
    end else if (st) begin
      exp_cy = 0; exp_sv = 0;
    end else if (v) begin
      total = int'(a) + int'(b) + exp_cy;
      exp_sb = total % 2;
      exp_cy = total / 2;
      exp_sv = 1;
    end else begin
      exp_sv = 0;
    end
    primed = 1'b1;
  endtask

  task automatic run_word(input logic [W-1:0] x, input logic [W-1:0] y,
                          input bit gaps, input bit dirty_start);
    logic [W:0] want;
    want = {1'b0, x} + {1'b0, y};
    got_word = '0;
    step(1'b0, 1'b1, dirty_start, dirty_start, dirty_start);
    for (int i = 0; i < W; i++) begin
      if (gaps && ($urandom % 3 == 0)) step(1'b0, 1'b0, 1'b0, $urandom % 2, $urandom % 2);
      step(1'b0, 1'b0, 1'b1, x[i], y[i]);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8: serial result against parallel addition
    check("R8 sum word", int'(got_word), int'(want[W-1:0]));
    check("R8 final carry", int'(carry_out), int'(want[W]));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES && !finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, MAX_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // R1 after reset, R4 zero word, R3 all ones
    run_word('0, '0, 1'b0, 1'b0);
    run_word('1, '1, 1'b0, 1'b0);
    // R5: a single generate propagating through all positions
    run_word('1, {{(W-1){1'b0}}, 1'b1}, 1'b0, 1'b0);
    // R7: a start cycle with a one-one pair must clear the carry left by the word before
    run_word('1, '1, 1'b0, 1'b0);
    run_word('0, '1, 1'b0, 1'b1);
    // R6: random operands with idle gaps
    for (int k = 0; k < 40; k++)
      run_word(W'($urandom), W'($urandom), 1'b1, k % 2 == 1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule